// File: doc/BRIEF.md
# Vector Register Layout Interleave Mapper

This block rearranges one vector register's worth of bytes between the order they have in memory and the order a sliced datapath keeps them in the register. The register is `VLEN` bits wide and is cut into `SLEN`-bit slices. A request carries a data word, an element width, one of four layout modes and a direction. Load goes from memory order to register order. Store goes from register order back to memory order. The block returns the rearranged word together with a per-byte write enable. A clear enable bit marks a byte that the destination must leave untouched.

The four layouts work as follows. The element-granular mode deals elements across the slices in turn, one element at a time. The flat mode keeps memory order unchanged. The two half-slice modes use only the lower half or only the upper half of every slice, in flat order. A request whose element width exceeds the slice width is refused through an error flag. Requests are accepted with a valid/ready handshake, and each result comes out of a single register stage.

Top module: `vec_interleave_mapper`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Mode 3 (flat) copies `in_data` to `out_data` unchanged in both directions, and every bit of `out_mask` is 1.
- R3: Mode 0 on load (`in_dir`=0), with `in_sew` code k giving an element of E=2^k bytes and with NS=VLEN/SLEN slices: memory element i (bytes i*E..i*E+E-1) lands in slice (i mod NS), slot (i div NS). Its register byte offset is (i mod NS)*SLEN/8 + (i div NS)*E. Every bit of `out_mask` is 1.
- R4: Mode 0 on store (`in_dir`=1) is the exact inverse of R3. A load followed by a store with the same width returns the original word.
- R5: Mode 1 on load puts memory bytes 0..VLEN/16-1 in order into the lower half of each slice, filling slice 0 first. The upper half of each slice has mask 0 and data 0.
- R6: Mode 2 on load does the same as R5 but uses the upper half of each slice. The lower halves have mask 0 and data 0.
- R7: Modes 1 and 2 on store gather the active half-slices back into memory bytes 0..VLEN/16-1. The upper half of the memory word has mask 0 and data 0. A load followed by a store returns the lower half of the original word.
- R8: When 8*2^k > SLEN, `out_err` is 1, and `out_mask` and `out_data` are all zero. Otherwise `out_err` is 0.
- R9: A request accepted at a rising edge shows up on `out_valid`/`out_data` right after that edge, so the latency is one cycle.
- R10: While `out_valid`=1 and `out_ready`=0, the outputs hold steady and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_data | input | VLEN | Word to rearrange |
| in_sew | input | 2 | Element width code: 0=8, 1=16, 2=32, 3=64 bits |
| in_mode | input | 2 | 0 element interleave, 1 lower half, 2 upper half, 3 flat |
| in_dir | input | 1 | 0 load (memory to register), 1 store |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result can be taken |
| out_data | output | VLEN | Rearranged word |
| out_mask | output | VLEN/8 | Per-byte write enable; 0 = leave undisturbed |
| out_err | output | 1 | Element width wider than a slice |

## Verification
Every result (data, mask and error) is due in the cycle right after the rising edge at which the request is accepted. The bench drives each request at a falling edge and reads the outputs at the next falling edge, one register later, with `out_ready` held high. For the stall case it instead holds `out_ready` low for several falling edges and rereads the same values each time. Round-trip checks feed a load result straight back as a store request in the following transfer.

// File: rtl/vlim_pkg.sv
// Package: shared encodings for the interleave mapper.
// Assumes nothing beyond IEEE 1800-2017 packages.
package vlim_pkg;

    typedef enum logic [1:0] {
        LAYOUT_DEAL  = 2'd0,
        LAYOUT_LOWER = 2'd1,
        LAYOUT_UPPER = 2'd2,
        LAYOUT_FLAT  = 2'd3
    } layout_e;

    typedef enum logic {
        DIR_LOAD  = 1'b0,
        DIR_STORE = 1'b1
    } dir_e;

endpackage

// File: rtl/vlim_route.sv
// Module: vlim_route
// Combinational byte router. For every output byte it works out which input
// byte feeds it and whether that byte is written at all.
// Assumes VLEN/SLEN and SLEN/8 are powers of two and SLEN >= 16.
module vlim_route #(
    parameter int VLEN = 128,
    parameter int SLEN = 32
) (
    input  logic [VLEN-1:0]   src_data,
    input  logic [1:0]        sew_code,
    input  logic [1:0]        layout,
    input  logic              dir,
    output logic [VLEN-1:0]   dst_data,
    output logic [VLEN/8-1:0] dst_en
);
    import vlim_pkg::*;

    localparam int VB  = VLEN / 8;
    localparam int CB  = SLEN / 8;
    localparam int NS  = VB / CB;
    localparam int HB  = CB / 2;

    for (genvar d = 0; d < VB; d++) begin : g_byte
        int src;
        logic en;
        int eb, sh, sl, rr, el, off;

        // Pick the source byte and write enable for output byte d.
        always_comb begin
            sh  = int'(sew_code);
            eb  = 1 << sh;
            sl  = d / CB;
            rr  = d % CB;
            el  = d >> sh;
            off = (layout_e'(layout) == LAYOUT_UPPER) ? HB : 0;
            src = d;
            en  = 1'b1;
            case (layout_e'(layout))
                LAYOUT_DEAL: begin
                    if (dir == DIR_LOAD)
                        src = (((rr >> sh) * NS) + sl) * eb + (rr & (eb - 1));
                    else
                        src = (el % NS) * CB + (el / NS) * eb + (d & (eb - 1));
                end
                LAYOUT_LOWER, LAYOUT_UPPER: begin
                    if (dir == DIR_LOAD) begin
                        en  = (rr >= off) && (rr < off + HB);
                        src = sl * HB + rr - off;
                    end else begin
                        en  = (d < VB / 2);
                        src = (d / HB) * CB + off + (d % HB);
                    end
                end
                default: begin
                    src = d;
                end
            endcase
            if (!en || src < 0 || src >= VB)
                src = 0;
        end

        // Drive the routed byte, zero for a gap byte.
        assign dst_data[8*d +: 8] = en ? src_data[8*src +: 8] : 8'h00;
        assign dst_en[d]          = en;
    end

endmodule

// File: rtl/vlim_stage.sv
// Module: vlim_stage
// Single register slice with a valid/ready handshake. It accepts whenever
// the slot is empty or is being drained in the same cycle.
module vlim_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up_valid,
    output logic         up_ready,
    input  logic [W-1:0] up_bits,
    output logic         dn_valid,
    input  logic         dn_ready,
    output logic [W-1:0] dn_bits
);
    // Take new data when the slot frees up.
    assign up_ready = !dn_valid || dn_ready;

    // Hold the occupancy flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dn_valid <= 1'b0;
        else if (up_ready)
            dn_valid <= up_valid;
    end

    // Capture the payload on accept.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dn_bits <= '0;
        else if (up_valid && up_ready)
            dn_bits <= up_bits;
    end

endmodule

// File: rtl/vec_interleave_mapper.sv
// Module: vec_interleave_mapper
// Top: routes one register word between memory and sliced register order,
// flags element widths wider than a slice and registers the result once.
// Assumes SLEN divides VLEN, both powers of two, SLEN >= 16.
module vec_interleave_mapper #(
    parameter int VLEN = 128,
    parameter int SLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [VLEN-1:0]   in_data,
    input  logic [1:0]        in_sew,
    input  logic [1:0]        in_mode,
    input  logic              in_dir,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [VLEN-1:0]   out_data,
    output logic [VLEN/8-1:0] out_mask,
    output logic              out_err
);
    localparam int VB = VLEN / 8;
    localparam int PW = VLEN + VB + 1;

    logic [VLEN-1:0] rt_data;
    logic [VB-1:0]   rt_en;
    logic            bad_sew;
    logic [PW-1:0]   nxt_bits;
    logic [PW-1:0]   cur_bits;

    vlim_route #(.VLEN(VLEN), .SLEN(SLEN)) u_route (
        .src_data (in_data),
        .sew_code (in_sew),
        .layout   (in_mode),
        .dir      (in_dir),
        .dst_data (rt_data),
        .dst_en   (rt_en)
    );

    // Flag an element wider than one slice and blank its result.
    always_comb begin
        bad_sew  = (8 << int'(in_sew)) > SLEN;
        nxt_bits = bad_sew ? {1'b1, {VB{1'b0}}, {VLEN{1'b0}}}
                           : {1'b0, rt_en, rt_data};
    end

    vlim_stage #(.W(PW)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .up_bits  (nxt_bits),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .dn_bits  (cur_bits)
    );

    // Split the registered payload onto the ports.
    assign out_err  = cur_bits[PW-1];
    assign out_mask = cur_bits[VLEN +: VB];
    assign out_data = cur_bits[VLEN-1:0];

endmodule

// File: rtl/vlim_checker.sv
// Module: vlim_checker
// Temporal properties for the mapper, attached by bind.
module vlim_checker #(
    parameter int VLEN = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [VLEN-1:0]   out_data,
    input logic [VLEN/8-1:0] out_mask,
    input logic              out_err
);
    AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid); // R9

    AST_STALL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_mask))); // R10

    AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R10

    AST_ERR_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_mask == '0 && out_data == '0)); // R8

endmodule

bind vec_interleave_mapper vlim_checker #(.VLEN(VLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_mask  (out_mask),
    .out_err   (out_err)
);

// File: tb/vec_interleave_mapper_test.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random traffic against a local model.
module vec_interleave_mapper_test;
    localparam int VLEN = 128;
    localparam int SLEN = 32;
    localparam int VB = VLEN / 8;
    localparam int CB = SLEN / 8;
    localparam int NS = VB / CB;
    localparam int HB = CB / 2;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_dir = 0, out_ready = 1;
    logic [1:0] in_sew = 0, in_mode = 0;
    logic [VLEN-1:0] in_data = '0;
    logic in_ready, out_valid, out_err;
    logic [VLEN-1:0] out_data;
    logic [VB-1:0] out_mask;
    int n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    vec_interleave_mapper #(.VLEN(VLEN), .SLEN(SLEN)) uut (.*);

    typedef struct packed { logic err; logic [VB-1:0] m; logic [VLEN-1:0] d; } res_t;

    // Expected result, built element by element from the requirements.
    function automatic res_t model(logic [VLEN-1:0] x, int k, int md, bit st);
        res_t r = '0;
        int eb = 1 << k;
        if (8 * eb > SLEN) begin r.err = 1; return r; end
        if (md == 3) begin r.d = x; r.m = '1; return r; end
        if (md == 0) begin
            r.m = '1;
            for (int e = 0; e < VB / eb; e++) begin
                int rp = (e % NS) * CB + (e / NS) * eb;
                for (int b = 0; b < eb; b++)
                    if (!st) r.d[8*(rp+b) +: 8] = x[8*(e*eb+b) +: 8];
                    else     r.d[8*(e*eb+b) +: 8] = x[8*(rp+b) +: 8];
            end
            return r;
        end
        for (int j = 0; j < VB / 2; j++) begin
            int rp = (j / HB) * CB + (md == 2 ? HB : 0) + j % HB;
            if (!st) begin r.d[8*rp +: 8] = x[8*j +: 8]; r.m[rp] = 1; end
            else     begin r.d[8*j +: 8] = x[8*rp +: 8]; r.m[j] = 1; end
        end
        return r;
    endfunction

    task automatic check(bit ok, string req, logic [VLEN+VB:0] act, logic [VLEN+VB:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // One transfer; result sampled one falling edge later.
    task automatic xfer(logic [VLEN-1:0] x, int k, int md, bit st, output res_t got);
        @(negedge clk);
        in_data = x; in_sew = 2'(k); in_mode = 2'(md); in_dir = st;
        in_valid = 1; out_ready = 1;
        @(negedge clk);
        in_valid = 0;
        got = '{err: out_err, m: out_mask, d: out_data};
        check(out_valid === 1'b1, "R9", {128'(out_valid)}, 1);
    endtask

    task automatic run_one(logic [VLEN-1:0] x, int k, int md, bit st, string req);
        res_t g, e;
        xfer(x, k, md, st, g);
        e = model(x, k, md, st);
        check(g === e, req, g, e);
    endtask

    // Load then store; the memory word must come back.
    task automatic round_trip(logic [VLEN-1:0] x, int k, int md, string req);
        res_t a, b;
        logic [VLEN-1:0] want;
        xfer(x, k, md, 0, a);
        xfer(a.d, k, md, 1, b);
        want = (md == 1 || md == 2) ? {{(VLEN/2){1'b0}}, x[VLEN/2-1:0]} : x;
        check(b.d === want, req, b.d, want);
    endtask

    initial begin
        #(8ns * 200000);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [VLEN-1:0] ramp;
        res_t g;
        logic [VLEN-1:0] held;
        void'($urandom(1234));
        for (int i = 0; i < VB; i++) ramp[8*i +: 8] = 8'(i);
        repeat (3) @(negedge clk);
        check(out_valid === 0 && in_ready === 1, "R1", {out_valid, in_ready}, 2'b01);
        rst_n = 1;

        // R2 flat
        run_one(ramp, 0, 3, 0, "R2");
        run_one(ramp, 2, 3, 1, "R2");
        // R3 explicit: register byte 1 holds memory byte NS (byte width)
        xfer(ramp, 0, 0, 0, g);
        check(g.d[15:8] === 8'(NS), "R3", g.d[15:8], NS);
        run_one(ramp, 1, 0, 0, "R3");
        run_one(ramp, 0, 0, 1, "R4");
        run_one(ramp, 0, 1, 0, "R5");
        run_one(ramp, 0, 2, 0, "R6");
        run_one(ramp, 1, 1, 1, "R7");
        run_one(ramp, 0, 2, 1, "R7");
        // R8 wide element
        xfer(ramp, 3, 0, 0, g);
        check(g.err === 1 && g.m === '0 && g.d === '0, "R8", g, 129'(1) << (VLEN+VB));
        run_one(ramp, 2, 0, 0, "R8");

        // R10 stall
        @(negedge clk);
        in_data = ramp; in_sew = 0; in_mode = 0; in_dir = 0; in_valid = 1; out_ready = 0;
        @(negedge clk);
        in_valid = 0;
        held = out_data;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check(out_valid === 1 && in_ready === 0 && out_data === held, "R10",
                  {out_valid, in_ready}, 2'b10);
        end
        out_ready = 1;
        @(negedge clk);

        // Random traffic and round trips
        for (int t = 0; t < 150; t++) begin
            logic [VLEN-1:0] x = {$urandom, $urandom, $urandom, $urandom};
            int k = $urandom % 4, md = $urandom % 4;
            bit st = 1'($urandom);
            run_one(x, k, md, st, md == 0 ? (st ? "R4" : "R3") : md == 3 ? "R2" :
                    st ? "R7" : md == 1 ? "R5" : "R6");
            if (k < 3) round_trip(x, k, md, (md == 1 || md == 2) ? "R7" : "R4");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule